// File: doc/BRIEF.md
# Hit Cluster Centroid Finder with Width Cut

This block takes one crossing's worth of binary hits from a single sensor layer of 128 local channels. It widens that vector by four channels on each side, which come from the adjacent chips. Runs of adjacent set channels form clusters. A cluster whose width exceeds a programmable limit is dropped. Each cluster that survives is reduced to a single marked channel at its centre. When a cluster has an even width, the mark goes on the left of the two middle channels.

The block also passes its own outermost four channels on each side to the neighbouring chips, so that a cluster crossing a chip boundary is seen whole on both sides. The centroid vector is registered once, so it is ready one clock after the hits are presented. A coincidence stage downstream takes it from there.

Top module: `cluster_centroid_finder`

## Requirements
- R1: `lft_nb_o` carries local channels 1..4 (`hit_i[3:0]`, bit 0 = channel 1) and `rgt_nb_o` carries channels 125..128 (`hit_i[127:124]`, bit 0 = channel 125). Both follow the inputs in the same cycle with no register.
- R2: The clustered vector has 136 positions. `lft_nb_i[j]` is channel j-3 (bit 0 = channel -3, bit 3 = channel 0), `hit_i[k]` is channel k+1, and `rgt_nb_i[j]` is channel 129+j. A cluster is a maximal run of consecutive set positions, and a lone hit gives a centroid on its own channel.
- R3: A cluster of odd width w starting at channel s has its centroid at channel s+(w-1)/2.
- R4: A cluster of even width w starting at channel s has its centroid at channel s+w/2-1, the left of the two middle channels.
- R5: With `cut_i` nonzero, a cluster wider than `cut_i` gives no centroid, and a cluster exactly `cut_i` wide is kept.
- R6: With `cut_i` equal to 0, no cluster is rejected, up to a run covering all 136 positions.
- R7: Neighbour channels cluster like local ones. A centroid that falls on channels -3..0 or 129..132 sets no output bit.
- R8: `cent_o[k-1]` marks channel k and reflects the inputs at the previous rising clock edge. It reads zero while `rst_n` is low and for the two edges after its release.
- R9: Clusters separated by at least one empty channel are independent. Each gets its own centroid and its own width test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cut_i | input | 4 | Maximum kept cluster width; 0 turns rejection off |
| hit_i | input | 128 | Local channel hits, bit k = channel k+1 |
| lft_nb_i | input | 4 | Hits of channels -3..0 from the left neighbour |
| rgt_nb_i | input | 4 | Hits of channels 129..132 from the right neighbour |
| lft_nb_o | output | 4 | Local channels 1..4 sent to the left neighbour |
| rgt_nb_o | output | 4 | Local channels 125..128 sent to the right neighbour |
| cent_o | output | 128 | One-hot-per-cluster centroid marks, bit k = channel k+1 |

## Verification
The block holds no state from one crossing to the next beyond the output register. A wrong run count or a miscompared width therefore shows up one clock after the offending hits, as a centroid shifted by a channel, a cluster split in two, or a wide cluster that is missing or present. An error in how the neighbour positions are stitched in shows only for clusters that touch the chip edges. For that reason the stimulus places runs across both boundaries and runs cut values on both sides of each width.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

  // Width of the cluster-width limit field.
  localparam int unsigned CUT_W = 4;

  typedef logic [CUT_W-1:0] cut_t;

  // Bits needed to count a run of up to n positions.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ccf_rst_sync.sv
module ccf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/ccf_edge_map.sv
module ccf_edge_map #(
  parameter int unsigned N_LOC  = 128,
  parameter int unsigned N_EDGE = 4,
  localparam int unsigned N_EXT = N_LOC + 2 * N_EDGE
) (
  input  logic [N_LOC-1:0]  hit_i,
  input  logic [N_EDGE-1:0] lft_nb_i,
  input  logic [N_EDGE-1:0] rgt_nb_i,
  output logic [N_EXT-1:0]  ext_o,
  output logic [N_EDGE-1:0] lft_nb_o,
  output logic [N_EDGE-1:0] rgt_nb_o
);

  // Position 0 is the outermost left-neighbour channel.
  assign ext_o    = {rgt_nb_i, hit_i, lft_nb_i};

  // Outermost local channels go to the adjacent chips unregistered.
  assign lft_nb_o = hit_i[N_EDGE-1:0];
  assign rgt_nb_o = hit_i[N_LOC-1 -: N_EDGE];

endmodule

// File: rtl/ccf_run_count.sv
module ccf_run_count #(
  parameter int unsigned N_LOC  = 128,
  parameter int unsigned N_EDGE = 4,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned N_EXT = N_LOC + 2 * N_EDGE,
  localparam int unsigned N_HALF = N_LOC + N_EDGE
) (
  input  logic [N_EXT-1:0]            ext_i,
  output logic [N_LOC-1:0][CNT_W-1:0] lcnt_o,
  output logic [N_LOC-1:0][CNT_W-1:0] rcnt_o
);

  // lrun[i]: set positions directly left of extended position i, in the same run.
  logic [N_HALF-1:0][CNT_W-1:0] lrun;
  // rrun[j]: set positions directly right of extended position N_EDGE+j.
  logic [N_HALF-1:0][CNT_W-1:0] rrun;

  always_comb begin
    lrun[0] = '0;
    for (int i = 1; i < int'(N_HALF); i++) begin
      lrun[i] = ext_i[i-1] ? lrun[i-1] + 1'b1 : '0;
    end
  end

  always_comb begin
    rrun[N_HALF-1] = '0;
    for (int j = int'(N_HALF) - 2; j >= 0; j--) begin
      rrun[j] = ext_i[N_EDGE+j+1] ? rrun[j+1] + 1'b1 : '0;
    end
  end

  assign lcnt_o = lrun[N_HALF-1 -: N_LOC];
  assign rcnt_o = rrun[N_LOC-1:0];

endmodule

// File: rtl/ccf_pick.sv
module ccf_pick #(
  parameter int unsigned N_LOC = 128,
  parameter int unsigned CNT_W = 8
) (
  input  logic [N_LOC-1:0]            hit_i,
  input  logic [N_LOC-1:0][CNT_W-1:0] lcnt_i,
  input  logic [N_LOC-1:0][CNT_W-1:0] rcnt_i,
  input  ccf_pkg::cut_t               cut_i,
  output logic [N_LOC-1:0]            cent_o
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic            no_cut;
  logic [SUM_W-1:0] lim;

  assign no_cut = (cut_i == '0);
  assign lim    = SUM_W'(cut_i);

  for (genvar g = 0; g < int'(N_LOC); g++) begin : g_ch
    logic             mid;
    logic [SUM_W-1:0] wid;
    logic             fits;

    // Centre when the right side is equal or one longer (left rounding).
    assign mid  = (rcnt_i[g] == lcnt_i[g]) || (rcnt_i[g] == lcnt_i[g] + 1'b1);
    assign wid  = {1'b0, lcnt_i[g]} + {1'b0, rcnt_i[g]} + 1'b1;
    assign fits = no_cut || (wid <= lim);
    assign cent_o[g] = hit_i[g] & mid & fits;
  end

endmodule

// File: rtl/cluster_centroid_finder.sv
module cluster_centroid_finder #(
  parameter int unsigned N_LOC  = 128,
  parameter int unsigned N_EDGE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ccf_pkg::CUT_W-1:0] cut_i,
  input  logic [N_LOC-1:0]          hit_i,
  input  logic [N_EDGE-1:0]         lft_nb_i,
  input  logic [N_EDGE-1:0]         rgt_nb_i,
  output logic [N_EDGE-1:0]         lft_nb_o,
  output logic [N_EDGE-1:0]         rgt_nb_o,
  output logic [N_LOC-1:0]          cent_o
);

  localparam int unsigned N_EXT = N_LOC + 2 * N_EDGE;
  localparam int unsigned CNT_W = ccf_pkg::cnt_bits(N_EXT);

  logic                      rst_q_n;
  logic [N_EXT-1:0]          ext;
  logic [N_LOC-1:0][CNT_W-1:0] lcnt;
  logic [N_LOC-1:0][CNT_W-1:0] rcnt;
  logic [N_LOC-1:0]          cent_d;
  logic [N_LOC-1:0]          cent_q;

  ccf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ccf_edge_map #(.N_LOC(N_LOC), .N_EDGE(N_EDGE)) u_map (
    .hit_i    (hit_i),
    .lft_nb_i (lft_nb_i),
    .rgt_nb_i (rgt_nb_i),
    .ext_o    (ext),
    .lft_nb_o (lft_nb_o),
    .rgt_nb_o (rgt_nb_o)
  );

  ccf_run_count #(.N_LOC(N_LOC), .N_EDGE(N_EDGE), .CNT_W(CNT_W)) u_cnt (
    .ext_i  (ext),
    .lcnt_o (lcnt),
    .rcnt_o (rcnt)
  );

  ccf_pick #(.N_LOC(N_LOC), .CNT_W(CNT_W)) u_pick (
    .hit_i  (hit_i),
    .lcnt_i (lcnt),
    .rcnt_i (rcnt),
    .cut_i  (cut_i),
    .cent_o (cent_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cent_q <= '0;
    end else begin
      cent_q <= cent_d;
    end
  end

  assign cent_o = cent_q;

endmodule

// File: rtl/ccf_chk.sv
module ccf_chk #(
  parameter int unsigned N_LOC  = 128,
  parameter int unsigned N_EDGE = 4,
  localparam int unsigned N_EXT = N_LOC + 2 * N_EDGE
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ccf_pkg::CUT_W-1:0] cut_i,
  input logic [N_LOC-1:0]          hit_i,
  input logic [N_EDGE-1:0]         lft_nb_i,
  input logic [N_EDGE-1:0]         rgt_nb_i,
  input logic [N_LOC-1:0]          cent_o
);

  logic [N_EXT-1:0]          seen_q;
  logic [ccf_pkg::CUT_W-1:0] cut_q;
  logic [N_EXT-1:0]          lone;
  logic [N_EXT-1:0]          touch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cut_q  <= '0;
    end else begin
      seen_q <= {rgt_nb_i, hit_i, lft_nb_i};
      cut_q  <= cut_i;
    end
  end

  assign lone  = seen_q & ~(seen_q << 1) & ~(seen_q >> 1);
  assign touch = (seen_q << 1) | (seen_q >> 1);

  // R9
  apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_o & (cent_o >> 1)) == '0);

  // R2
  on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_o & ~seen_q[N_EDGE +: N_LOC]) == '0);

  // R2
  lone_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lone[N_EDGE +: N_LOC] & ~cent_o) == '0);

  // R5
  cut_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q == 4'd1) |-> ((cent_o & touch[N_EDGE +: N_LOC]) == '0));

endmodule

bind cluster_centroid_finder ccf_chk #(.N_LOC(N_LOC), .N_EDGE(N_EDGE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .cut_i    (cut_i),
  .hit_i    (hit_i),
  .lft_nb_i (lft_nb_i),
  .rgt_nb_i (rgt_nb_i),
  .cent_o   (cent_o)
);

// File: tb/sim_cluster_centroid_finder.sv
module sim_cluster_centroid_finder;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic [3:0]   cut;
  logic [127:0] hit;
  logic [3:0]   lin;
  logic [3:0]   rin;
  logic [3:0]   lout;
  logic [3:0]   rout;
  logic [127:0] cent;

  int checks = 0;
  int bad = 0;
  logic [127:0] prev_exp = '0;

  cluster_centroid_finder u0 (
    .clk(clk), .rst_n(rst_n), .cut_i(cut), .hit_i(hit),
    .lft_nb_i(lin), .rgt_nb_i(rin), .lft_nb_o(lout), .rgt_nb_o(rout),
    .cent_o(cent)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Model: walk runs, place mark at first + (width-1)/2 in extended
  // coordinates (channel = position - 3), keep local channels 1..128 only.
  function automatic logic [127:0] ref_cent(input logic [135:0] v, input logic [3:0] c);
    logic [127:0] r;
    int p;
    r = '0;
    p = 0;
    while (p < 136) begin
      if (v[p]) begin
        int s;
        int w;
        int m;
        s = p;
        while (p < 136 && v[p]) p++;
        w = p - s;
        m = s + (w - 1) / 2;
        if ((c == 0 || w <= int'(c)) && m >= 4 && m < 132) r[m-4] = 1'b1;
      end else begin
        p++;
      end
    end
    return r;
  endfunction

  task automatic apply(input logic [3:0] l, input logic [127:0] h,
                       input logic [3:0] r, input logic [3:0] c, input string tag);
    logic [127:0] exp;
    @(negedge clk);
    lin = l; hit = h; rin = r; cut = c;
    #1;
    checks++;
    if (cent !== prev_exp) begin
      bad++;
      $display("FAIL R8 %s: output moved before edge, got %h expected %h", tag, cent, prev_exp);
    end
    checks++;
    if (lout !== h[3:0] || rout !== h[127:124]) begin
      bad++;
      $display("FAIL R1 %s: edges got %h/%h expected %h/%h", tag, lout, rout, h[3:0], h[127:124]);
    end
    @(negedge clk);
    exp = ref_cent({r, h, l}, c);
    checks++;
    if (cent !== exp) begin
      bad++;
      $display("FAIL %s: centroids got %h expected %h", tag, cent, exp);
    end
    prev_exp = exp;
  endtask

  task automatic directed(input logic [3:0] l, input logic [127:0] h, input logic [3:0] r,
                          input logic [3:0] c, input logic [127:0] hand, input string tag);
    apply(l, h, r, c, tag);
    checks++;
    if (cent !== hand) begin
      bad++;
      $display("FAIL %s: centroids got %h expected %h", tag, cent, hand);
    end
  endtask

  function automatic logic [127:0] span(input int lo_ch, input int hi_ch);
    logic [127:0] v;
    v = '0;
    for (int k = lo_ch; k <= hi_ch; k++) v[k-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [127:0] one(input int ch);
    logic [127:0] v;
    v = '0;
    v[ch-1] = 1'b1;
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cut = 4'd0; hit = '1; lin = '1; rin = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (cent !== '0) begin
      bad++;
      $display("FAIL R8 reset: got %h expected 0", cent);
    end
    hit = '0; lin = '0; rin = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (cent !== '0) begin
      bad++;
      $display("FAIL R8 after release: got %h expected 0", cent);
    end

    directed(4'h0, one(50), 4'h0, 4'd0, one(50), "R2 lone hit");
    directed(4'h0, span(10, 12), 4'h0, 4'd0, one(11), "R3 odd width 3");
    directed(4'h0, span(20, 23), 4'h0, 4'd0, one(21), "R4 even width 4");
    directed(4'h0, span(30, 32) | span(40, 43), 4'h0, 4'd3, one(31), "R5 cut 3 keeps 3 drops 4");
    directed(4'h0, span(60, 75) | span(80, 94), 4'h0, 4'd15, one(87), "R5 cut 15 keeps 15 drops 16");
    directed(4'hf, '1, 4'hf, 4'd0, one(64), "R6 full 136 run no cut");
    directed(4'h0, span(100, 119), 4'h0, 4'd0, one(109), "R6 width 20 no cut");
    directed(4'hf, span(1, 2), 4'h0, 4'd0, '0, "R7 centroid on left neighbour");
    directed(4'h8, span(1, 2), 4'h0, 4'd0, one(1), "R7 left stitch width 3");
    directed(4'h0, one(128), 4'h7, 4'd0, '0, "R7 centroid on right neighbour");
    directed(4'h0, span(127, 128), 4'h1, 4'd0, one(128), "R7 right stitch width 3");
    directed(4'h5, '0, 4'ha, 4'd0, '0, "R7 neighbour only hits");
    directed(4'h0, one(5) | span(7, 8) | span(10, 14), 4'h0, 4'd4, one(5) | one(7),
             "R9 separate clusters own cut");
    directed(4'h0, 128'h5555_5555_5555_5555_5555_5555_5555_5555, 4'h0, 4'd1,
             128'h5555_5555_5555_5555_5555_5555_5555_5555, "R9 alternating singles");

    for (int n = 0; n < 3000; n++) begin
      logic [127:0] h;
      logic [3:0] l;
      logic [3:0] r;
      int dens;
      case ($urandom_range(3))
        0: dens = 10;
        1: dens = 35;
        2: dens = 65;
        default: dens = 92;
      endcase
      for (int k = 0; k < 128; k++) h[k] = ($urandom_range(99) < dens);
      for (int k = 0; k < 4; k++) begin
        l[k] = ($urandom_range(99) < dens);
        r[k] = ($urandom_range(99) < dens);
      end
      apply(l, h, r, 4'($urandom_range(15)), "R2 R3 R4 R5 R6 R7 random");
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule